// File: doc/BRIEF.md
# Serial Port Sample-Rate Clock Generator

This block derives a data clock for a serial port from one of three input clocks: the fast system clock itself, a receive-side clock pin or a transmit-side clock pin. Everything runs on the system clock. The two external clock pins and a frame-sync input are sampled there and their edges are detected. The chosen edge, with the chosen polarity, becomes an input tick. A preloaded down-counter divides the ticks by a programmable ratio of 1 to 256.

The block produces three outputs. `clkg` is the divided clock level. `clkg_en` is a one-cycle enable that marks the start of each output period. `fsg` is a one-cycle strobe raised when the divider is restarted by a frame-sync edge. Restart only happens when sync is enabled and the receive pin is the source. In that mode the local divider keeps the same phase as an external device that divides the same pin clock.

The external clocks must run at no more than a quarter of the system clock rate. Each pin edge reaches the outputs three system clock edges after it is first sampled: two synchronizer flops, then the output register.

Top module: `srg_clkgen`

## Requirements
- R1: While `rst_n` is low, and at the first clock edge with it low, `clkg`, `clkg_en` and `fsg` are all 0.
- R2: With `src_sel` = 2'b00 (internal), every system clock cycle is an input tick, whatever the polarity inputs hold.
- R3: With `src_sel` = 2'b01 (receive pin), `rx_pol` = 0 makes the falling edge of `rx_clk_pin` the tick and `rx_pol` = 1 makes its rising edge the tick.
- R4: With `src_sel` = 2'b10 (transmit pin), `tx_pol` = 0 makes the rising edge of `tx_clk_pin` the tick and `tx_pol` = 1 makes its falling edge the tick.
- R5: With `src_sel` = 2'b11 (reserved), no ticks occur. `clkg` holds its level and `clkg_en` stays 0.
- R6: The output period is `div_val` + 1 ticks. `clkg_en` pulses for one system cycle at the tick that starts each period, and `clkg` is high from that tick on.
- R7: For an even ratio (`div_val` odd), `clkg` is high for half of the period and low for the other half. For `div_val` = 0, `clkg_en` pulses on every tick and `clkg` stays high.
- R8: For an odd ratio 2p+1 (`div_val` = 2p, p > 0), `clkg` is high for p+1 ticks and low for p ticks.
- R9: A new `div_val` is taken only when the counter reloads, at the start of the next period.
- R10: With `sync_en` = 1 and `src_sel` = 2'b01, a rising edge on `fsync_in` restarts the period at the next tick. That tick raises `clkg_en` and `fsg` together for one cycle.
- R11: With `sync_en` = 0, or with any source other than the receive pin, `fsync_in` has no effect: `fsg` stays 0 and the period is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x any external clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 2 | Source: 00 internal, 01 receive pin, 10 transmit pin, 11 reserved |
| rx_pol | input | 1 | Receive-pin edge: 0 falling, 1 rising |
| tx_pol | input | 1 | Transmit-pin edge: 0 rising, 1 falling |
| div_val | input | 8 | Divide field; ratio is value + 1 |
| sync_en | input | 1 | Enables frame-sync restart of the divider |
| rx_clk_pin | input | 1 | External receive-side clock (asynchronous) |
| tx_clk_pin | input | 1 | External transmit-side clock (asynchronous) |
| fsync_in | input | 1 | External frame-sync, active high (asynchronous) |
| clkg | output | 1 | Divided clock level |
| clkg_en | output | 1 | One-cycle pulse at the start of each output period |
| fsg | output | 1 | One-cycle strobe on a sync restart |

## Verification
The divider is first run from the internal source with ratios 1, 4, 5 and 256. These separate the pass-through case, the equal split and the high-one-longer split, and they show whether the full 8-bit count is used. The divide field is then changed in the middle of a period, which shows whether the new value is taken early or only at reload. Free-running pin clocks with different periods on the two pins, each tried with both polarity settings, show which pin and which edge drive the ticks. The reserved code must freeze the outputs. Frame-sync pulses are applied with sync enabled, with sync disabled and with the internal source, which shows that a restart happens only in the one allowed combination.

// File: rtl/srg_pkg.sv
// Package: shared encodings for the sample-rate clock generator.
// Assumes: src_sel is decoded only through this type.
package srg_pkg;
    typedef enum logic [1:0] {
        SRC_INTERNAL = 2'b00,
        SRC_RX_PIN   = 2'b01,
        SRC_TX_PIN   = 2'b10,
        SRC_RESERVED = 2'b11
    } srg_src_e;
endpackage

// File: rtl/srg_pin_sync.sv
// Module: srg_pin_sync
// Brings one asynchronous pin into the system clock domain through a
// STAGES-deep flop chain and exposes the last synchronized level together
// with the level one cycle older, for edge detection downstream.
// Assumes: the pin stays stable for at least two system clock cycles.
module srg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl_now,
    output logic lvl_prev
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    // Shift the pin through the synchronizer and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], pin};
        end
    end

    assign lvl_now  = chain_q[STAGES-1];
    assign lvl_prev = chain_q[STAGES];
endmodule

// File: rtl/srg_tick_sel.sv
// Module: srg_tick_sel
// Picks the input tick from the internal clock or from the polarity-adjusted
// edge of one external pin, and qualifies frame-sync edges for resync.
// Assumes: pin levels come from srg_pin_sync, one cycle apart.
module srg_tick_sel
    import srg_pkg::*;
(
    input  logic [1:0] src_sel,
    input  logic       rx_pol,
    input  logic       tx_pol,
    input  logic       sync_en,
    input  logic       rx_now,
    input  logic       rx_prev,
    input  logic       tx_now,
    input  logic       tx_prev,
    input  logic       fs_now,
    input  logic       fs_prev,
    output logic       tick,
    output logic       sync_allow,
    output logic       resync_req
);
    logic rx_rise, rx_fall, tx_rise, tx_fall, fs_rise;

    // Edge detection on the synchronized levels.
    always_comb begin
        rx_rise = rx_now & ~rx_prev;
        rx_fall = ~rx_now & rx_prev;
        tx_rise = tx_now & ~tx_prev;
        tx_fall = ~tx_now & tx_prev;
        fs_rise = fs_now & ~fs_prev;
    end

    // Source and polarity selection; reserved code yields no ticks.
    always_comb begin
        case (srg_src_e'(src_sel))
            SRC_INTERNAL: tick = 1'b1;
            SRC_RX_PIN:   tick = rx_pol ? rx_rise : rx_fall;
            SRC_TX_PIN:   tick = tx_pol ? tx_fall : tx_rise;
            default:      tick = 1'b0;
        endcase
    end

    // Resync is honoured only when enabled with the receive pin as source.
    always_comb begin
        sync_allow = sync_en && (srg_src_e'(src_sel) == SRC_RX_PIN);
        resync_req = sync_allow && fs_rise;
    end
endmodule

// File: rtl/srg_divider.sv
// Module: srg_divider
// Down-counter divider: reloads with div_val at period start and shapes
// clkg so that the high phase is ceil(ratio/2) ticks. A pending resync
// forces a reload on the next tick and raises fsg with it.
// Assumes: tick is a single-cycle qualifier in the system clock domain.
module srg_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sync_allow,
    input  logic             resync_req,
    input  logic [DIV_W-1:0] div_val,
    output logic             clkg,
    output logic             clkg_en,
    output logic             fsg
);
    localparam int EXT_W = DIV_W + 1;

    logic [DIV_W-1:0] cnt_q, dv_q, cnt_d, dv_d;
    logic [EXT_W-1:0] low_len;
    logic             pend_q, restart, reload, clkg_q, clkg_d, en_q, fsg_q;

    // Next-state for counter, latched ratio and clock level.
    always_comb begin
        restart = tick && sync_allow && (pend_q || resync_req);
        reload  = tick && ((cnt_q == '0) || restart);
        dv_d    = reload ? div_val : dv_q;
        cnt_d   = reload ? div_val : (cnt_q - 1'b1);
        low_len = ({1'b0, dv_d} + 1'b1) >> 1;
        clkg_d  = ({1'b0, cnt_d} >= low_len);
    end

    // Divider state advances only on input ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            dv_q   <= '0;
            clkg_q <= 1'b0;
        end else if (tick) begin
            cnt_q  <= cnt_d;
            dv_q   <= dv_d;
            clkg_q <= clkg_d;
        end
    end

    // Single-cycle period-start and restart strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            fsg_q <= 1'b0;
        end else begin
            en_q  <= reload;
            fsg_q <= restart;
        end
    end

    // Remember a frame-sync edge until the next tick consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n || !sync_allow) begin
            pend_q <= 1'b0;
        end else if (restart) begin
            pend_q <= 1'b0;
        end else if (resync_req) begin
            pend_q <= 1'b1;
        end
    end

    assign clkg    = clkg_q;
    assign clkg_en = en_q;
    assign fsg     = fsg_q;
endmodule

// File: rtl/srg_clkgen.sv
// Module: srg_clkgen (top)
// Sample-rate clock generator: synchronizes the external pins, selects the
// input tick and divides it into clkg / clkg_en, with optional resync.
// Assumes: system clock at least 4x faster than any external clock.
module srg_clkgen #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src_sel,
    input  logic             rx_pol,
    input  logic             tx_pol,
    input  logic [DIV_W-1:0] div_val,
    input  logic             sync_en,
    input  logic             rx_clk_pin,
    input  logic             tx_clk_pin,
    input  logic             fsync_in,
    output logic             clkg,
    output logic             clkg_en,
    output logic             fsg
);
    localparam int N_PINS = 3;

    logic [N_PINS-1:0] pins, lvl_now, lvl_prev;
    logic              tick, sync_allow, resync_req;

    assign pins = {fsync_in, tx_clk_pin, rx_clk_pin};

    // One synchronizer per asynchronous pin: 0 rx, 1 tx, 2 frame-sync.
    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        srg_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (pins[g]),
            .lvl_now  (lvl_now[g]),
            .lvl_prev (lvl_prev[g])
        );
    end

    srg_tick_sel sel_i (
        .src_sel    (src_sel),
        .rx_pol     (rx_pol),
        .tx_pol     (tx_pol),
        .sync_en    (sync_en),
        .rx_now     (lvl_now[0]),
        .rx_prev    (lvl_prev[0]),
        .tx_now     (lvl_now[1]),
        .tx_prev    (lvl_prev[1]),
        .fs_now     (lvl_now[2]),
        .fs_prev    (lvl_prev[2]),
        .tick       (tick),
        .sync_allow (sync_allow),
        .resync_req (resync_req)
    );

    srg_divider #(.DIV_W(DIV_W)) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .sync_allow (sync_allow),
        .resync_req (resync_req),
        .div_val    (div_val),
        .clkg       (clkg),
        .clkg_en    (clkg_en),
        .fsg        (fsg)
    );
endmodule

// File: rtl/srg_clkgen_chk.sv
// Module: srg_clkgen_chk
// Port-level assertions for srg_clkgen, attached with bind below.
// Assumes: synchronous active-low reset on rst_n.
module srg_clkgen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] src_sel,
    input logic       sync_en,
    input logic       clkg,
    input logic       clkg_en,
    input logic       fsg
);
    AST_EN_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        clkg_en |-> clkg); // R6

    AST_FSG_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fsg |-> clkg_en); // R10

    AST_NO_FSG_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_en || src_sel != 2'b01) |=> !fsg); // R11

    AST_RESERVED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'b11) |=> (!clkg_en && $stable(clkg))); // R5
endmodule

bind srg_clkgen srg_clkgen_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_sel (src_sel),
    .sync_en (sync_en),
    .clkg    (clkg),
    .clkg_en (clkg_en),
    .fsg     (fsg)
);

// File: tb/srg_clkgen_tb_top.sv
// Bench: behavioural reference model compared on every clock.
module srg_clkgen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic       rx_pol = 1'b0, tx_pol = 1'b0, sync_en = 1'b0;
    logic [7:0] div_val = 8'd0;
    logic       rx_clk_pin = 1'b0, tx_clk_pin = 1'b0, fsync_in = 1'b0;
    logic       clkg, clkg_en, fsg;

    int    n_run = 0, n_fail = 0, fsg_cnt = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #2 clk = ~clk;

    srg_clkgen dut_i (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .rx_pol(rx_pol),
        .tx_pol(tx_pol), .div_val(div_val), .sync_en(sync_en),
        .rx_clk_pin(rx_clk_pin), .tx_clk_pin(tx_clk_pin),
        .fsync_in(fsync_in), .clkg(clkg), .clkg_en(clkg_en), .fsg(fsg)
    );

    // Reference model state.
    bit rx_h[$], tx_h[$], fs_h[$];
    int pos, ratio;
    bit pend, m_clkg, m_en, m_fsg;

    // Reference model: pin edges seen two cycles after sampling.
    always @(posedge clk) begin
        bit rr, rf, tr, tf, fr, tk, allow, req, rst_evt;
        if (!rst_n) begin
            rx_h = '{0, 0, 0, 0}; tx_h = '{0, 0, 0, 0}; fs_h = '{0, 0, 0, 0};
            pos = 0; ratio = 1; pend = 0; m_clkg = 0; m_en = 0; m_fsg = 0;
        end else begin
            rx_h.push_front(rx_clk_pin); void'(rx_h.pop_back());
            tx_h.push_front(tx_clk_pin); void'(tx_h.pop_back());
            fs_h.push_front(fsync_in);   void'(fs_h.pop_back());
            rr = rx_h[2] && !rx_h[3]; rf = !rx_h[2] && rx_h[3];
            tr = tx_h[2] && !tx_h[3]; tf = !tx_h[2] && tx_h[3];
            fr = fs_h[2] && !fs_h[3];
            case (src_sel)
                2'b00: tk = 1;
                2'b01: tk = rx_pol ? rr : rf;
                2'b10: tk = tx_pol ? tf : tr;
                default: tk = 0;
            endcase
            allow = sync_en && src_sel == 2'b01;
            req = allow && fr;
            rst_evt = tk && allow && (pend || req);
            m_en = 0; m_fsg = rst_evt;
            if (tk) begin
                if (rst_evt || pos == ratio - 1) begin
                    pos = 0; ratio = int'(div_val) + 1; m_en = 1; m_clkg = 1;
                end else begin
                    pos++;
                    m_clkg = pos < (ratio + 1) / 2;
                end
            end
            if (!allow || rst_evt) pend = 0;
            else if (req) pend = 1;
        end
    end

    // Compare on every cycle, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            n_run++;
            if ({clkg, clkg_en, fsg} !== {m_clkg, m_en, m_fsg}) begin
                n_fail++;
                $display("FAIL %s: actual clkg/en/fsg=%b%b%b expected %b%b%b at %0t",
                         cur_req, clkg, clkg_en, fsg, m_clkg, m_en, m_fsg, $time);
            end
            if (fsg === 1'b1) fsg_cnt++;
        end
    end

    // Free-running external clocks: rx half-period 5, tx half-period 6.
    initial begin
        int rc = 0, tc = 0;
        forever begin
            @(negedge clk);
            rc++; tc++;
            if (rc == 5) begin rc = 0; rx_clk_pin = ~rx_clk_pin; end
            if (tc == 6) begin tc = 0; tx_clk_pin = ~tx_clk_pin; end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_cnt(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fs_pulse();
        fsync_in = 1'b1; run(30);
        fsync_in = 1'b0; run(30);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        run(3);
        cur_req = "R1";
        check_cnt("R1", {clkg, clkg_en, fsg}, 0);
        rst_n = 1'b1;
        cur_req = "R2"; src_sel = 2'b00; rx_pol = 1; tx_pol = 1; run(12);
        cur_req = "R7"; div_val = 8'd0; run(12);
        div_val = 8'd3; run(40);
        cur_req = "R8"; div_val = 8'd4; run(40);
        div_val = 8'd6; run(40);
        cur_req = "R6"; div_val = 8'd255; run(600);
        cur_req = "R9"; div_val = 8'd9; run(13); div_val = 8'd2; run(40);
        cur_req = "R3"; src_sel = 2'b01; rx_pol = 0; run(100);
        rx_pol = 1; run(100);
        cur_req = "R4"; src_sel = 2'b10; tx_pol = 0; run(100);
        tx_pol = 1; run(100);
        cur_req = "R5"; src_sel = 2'b11; run(60);
        cur_req = "R10"; src_sel = 2'b01; rx_pol = 1; div_val = 8'd5;
        sync_en = 1; run(27); fsg_cnt = 0;
        fs_pulse(); fs_pulse();
        check_cnt("R10", fsg_cnt, 2);
        cur_req = "R11"; sync_en = 0; fsg_cnt = 0;
        fs_pulse(); fs_pulse();
        src_sel = 2'b00; sync_en = 1; fs_pulse();
        check_cnt("R11", fsg_cnt, 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule